// File: doc/BRIEF.md
# Clock Park-and-Restore Sequencer

This block orders the two mux control bits around a CPU clock path while the upstream PLL is retuned. Before the PLL changes, a *park* request moves the CPU clock onto the crystal by clearing the output-select bit. A settle window then runs, and after it the source-select bit is set so that the divider is fed from the system PLL. After the PLL has locked at its new rate, a *restore* request sets the output-select bit so that the divider output drives the CPU clock again. A second settle window follows, and only after it does the block report that the phase is finished.

The settle window is a parameter, `SETTLE_CYCLES`, counted in cycles of the reference clock that runs the block. For a 100 µs window on a 24 MHz crystal it is 2400. While a phase is running, `busy` is high. Each finished phase ends with a one-cycle `done` pulse. The block ignores any request it cannot accept and records the event in a sticky error flag that software clears.

Top module: `clk_park_seq`

## Requirements
- R1: After reset, `out_sel`, `src_sel`, `busy`, `done` and `err` are all 0.
- R2: A park request (`park_req`=1, `restore_req`=0) sampled while idle drives `out_sel` to 0 (crystal) on that clock edge. `src_sel` keeps its value through the following `SETTLE_CYCLES`-1 edges.
- R3: Exactly `SETTLE_CYCLES` edges after a park request is accepted, `src_sel` becomes 1 (PLL feeds the divider) and `done` pulses. `out_sel` stays 0.
- R4: A restore request (`restore_req`=1, `park_req`=0) sampled while idle drives `out_sel` to 1 (divider output) on that edge. `src_sel` is unchanged, and `done` pulses exactly `SETTLE_CYCLES` edges later.
- R5: `done` lasts one cycle and occurs once per accepted phase. `busy` is 1 from the accepting edge until the edge that raises `done`, and it is 0 while `done` is high. A request sampled in the cycle `done` is high is accepted.
- R6: A request sampled while `busy` is 1 is ignored: neither mux bit changes and the running phase ends at its original time. The request sets `err`.
- R7: Park and restore requested in the same idle cycle are both ignored (no mux change, `busy` stays 0, no `done`), and `err` is set.
- R8: `err` stays 1 until `err_clr` is sampled high. If a new error and `err_clr` coincide, `err` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference (crystal) clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| park_req | input | 1 | Pre-change request pulse: park the CPU clock on the crystal |
| restore_req | input | 1 | Post-change request pulse: return the CPU clock to the divider |
| err_clr | input | 1 | Clears the sticky error flag |
| out_sel | output | 1 | Output mux control: 0 = crystal, 1 = divider output |
| src_sel | output | 1 | Source mux control: 1 = system PLL feeds the divider |
| busy | output | 1 | High while a phase is in progress |
| done | output | 1 | One-cycle pulse at the end of each phase |
| err | output | 1 | Sticky flag for ignored requests |

## Verification
Park and restore phases are run both with idle gaps between them and back to back, with each new request issued in the cycle `done` is high. Comparing the two shows whether the sequencer returns to idle early enough to accept a request in its completion cycle, and whether the settle count reloads correctly. Each phase is timed against a queue of expected completion cycles and mux values, so a settle window that is one cycle short or long, or a source bit set too early, shows up as a mismatch. A request during a running phase, a simultaneous park-and-restore request, and a clear that collides with a new error each set `err` without moving the mux bits. These cases separate the request-rejection logic from the phase logic.

// File: rtl/clk_park_pkg.sv
package clk_park_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PARK    = 2'd1,
    ST_RESTORE = 2'd2
  } park_state_e;
endpackage

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int unsigned CYCLES = 2400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load) cnt_d = RELOAD;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/err_flag.sv
module err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic err
);
  logic err_q, err_d, err_en;

  always_comb begin
    err_en = set || clr;
    err_d  = set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end

  assign err = err_q;

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !clr |=> err_q);
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> err_q);
endmodule

// File: rtl/park_fsm.sv
module park_fsm
  import clk_park_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic park_req,
  input  logic restore_req,
  input  logic expired,
  output logic load,
  output logic reject,
  output logic out_sel,
  output logic src_sel,
  output logic busy,
  output logic done
);
  park_state_e state_q, state_d;
  logic out_q, out_d, src_q, src_d, done_q, done_d;
  logic idle, accept_park, accept_restore, finish;

  always_comb begin
    idle           = (state_q == ST_IDLE);
    accept_park    = idle && park_req && !restore_req;
    accept_restore = idle && restore_req && !park_req;
    reject         = (park_req || restore_req) && !(accept_park || accept_restore);
    finish         = !idle && expired;
    load           = accept_park || accept_restore;

    state_d = state_q;
    out_d   = out_q;
    src_d   = src_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept_park) begin
          out_d   = 1'b0;
          state_d = ST_PARK;
        end else if (accept_restore) begin
          out_d   = 1'b1;
          state_d = ST_RESTORE;
        end
      end
      ST_PARK: begin
        if (finish) begin
          src_d   = 1'b1;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_RESTORE: begin
        if (finish) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      out_q   <= 1'b0;
      src_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      out_q   <= out_d;
      src_q   <= src_d;
      done_q  <= done_d;
    end
  end

  assign out_sel = out_q;
  assign src_sel = src_q;
  assign busy    = !idle;
  assign done    = done_q;

  a_r3_src_only_when_parked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_sel) |-> !out_sel && done);
  a_r5_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r5_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r2_park_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_sel) |-> (state_q == ST_PARK) && busy);
  a_r4_restore_keeps_src: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RESTORE) |-> $stable(src_sel));
  a_r6_busy_ignores_req: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (park_req || restore_req) |=> $stable(out_sel));
endmodule

// File: rtl/clk_park_seq.sv
module clk_park_seq #(
  parameter int unsigned SETTLE_CYCLES = 2400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic park_req,
  input  logic restore_req,
  input  logic err_clr,
  output logic out_sel,
  output logic src_sel,
  output logic busy,
  output logic done,
  output logic err
);
  logic load, expired, reject;

  initial begin
    if (SETTLE_CYCLES < 1) $error("SETTLE_CYCLES must be at least 1");
  end

  park_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .park_req    (park_req),
    .restore_req (restore_req),
    .expired     (expired),
    .load        (load),
    .reject      (reject),
    .out_sel     (out_sel),
    .src_sel     (src_sel),
    .busy        (busy),
    .done        (done)
  );

  settle_timer #(.CYCLES(SETTLE_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .expired (expired)
  );

  err_flag u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (reject),
    .clr   (err_clr),
    .err   (err)
  );

  a_r7_pair_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && park_req && restore_req |=> !busy && err);
endmodule

// File: tb/clk_park_seq_bench.sv
module clk_park_seq_bench;
  localparam int N = 6;

  logic clk, rst_n, park_req, restore_req, err_clr;
  logic out_sel, src_sel, busy, done, err;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;

  typedef struct { int due; bit exp_out; bit exp_src; } exp_t;
  exp_t q[$];

  clk_park_seq #(.SETTLE_CYCLES(N)) u_clk_park_seq (
    .clk(clk), .rst_n(rst_n), .park_req(park_req), .restore_req(restore_req),
    .err_clr(err_clr), .out_sel(out_sel), .src_sel(src_sel), .busy(busy),
    .done(done), .err(err)
  );

  initial clk = 0;
  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Monitor: pop expected completions as done pulses appear
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) chk(0, "R5 unexpected done", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(cyc == e.due, "R3 done timing", cyc, e.due);
        chk(out_sel == e.exp_out, "R3 out_sel at done", out_sel, e.exp_out);
        chk(src_sel == e.exp_src, "R3 src_sel at done", src_sel, e.exp_src);
      end
    end
  end

  // Driver: called at a negedge; returns at the negedge where done is high
  task automatic run_phase(input bit is_park, input bit exp_out, input bit src_before, input bit src_after);
    exp_t e;
    e.due = cyc + 1 + N; e.exp_out = exp_out; e.exp_src = src_after;
    q.push_back(e);
    park_req = is_park; restore_req = !is_park;
    @(negedge clk);
    park_req = 0; restore_req = 0;
    chk(out_sel == exp_out, is_park ? "R2 out_sel on accept" : "R4 out_sel on accept", out_sel, exp_out);
    chk(busy == 1, "R5 busy after accept", busy, 1);
    chk(src_sel == src_before, is_park ? "R2 src_sel held" : "R4 src_sel held", src_sel, src_before);
    repeat (N - 1) @(negedge clk);
    chk(done == 0, "R5 no early done", done, 0);
    chk(src_sel == src_before, "R2 src_sel before window end", src_sel, src_before);
    @(negedge clk);
    chk(busy == 0, "R5 busy low with done", busy, 0);
  endtask

  initial begin
    exp_t e;
    rst_n = 0; park_req = 0; restore_req = 0; err_clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(out_sel == 0, "R1 out_sel", out_sel, 0);
    chk(src_sel == 0, "R1 src_sel", src_sel, 0);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(done == 0, "R1 done", done, 0);
    chk(err == 0, "R1 err", err, 0);

    run_phase(1, 0, 0, 1);
    @(negedge clk);
    run_phase(0, 1, 1, 1);
    // R5 back to back: requests in done cycle
    run_phase(1, 0, 1, 1);
    run_phase(0, 1, 1, 1);
    @(negedge clk);

    // R6: request during busy
    e.due = cyc + 1 + N; e.exp_out = 0; e.exp_src = 1; q.push_back(e);
    park_req = 1; @(negedge clk); park_req = 0;
    @(negedge clk);
    restore_req = 1; @(negedge clk); restore_req = 0;
    chk(err == 1, "R6 err set", err, 1);
    chk(out_sel == 0, "R6 out_sel unchanged", out_sel, 0);
    while (cyc < e.due) @(negedge clk);
    @(negedge clk);
    chk(out_sel == 0, "R6 ignored restore", out_sel, 0);
    chk(busy == 0, "R6 no extra phase", busy, 0);

    // R8 sticky and clear
    repeat (5) @(negedge clk);
    chk(err == 1, "R8 err sticky", err, 1);
    err_clr = 1; @(negedge clk); err_clr = 0;
    chk(err == 0, "R8 err cleared", err, 0);

    // R7 simultaneous requests while idle
    park_req = 1; restore_req = 1; @(negedge clk);
    park_req = 0; restore_req = 0;
    chk(err == 1, "R7 err set", err, 1);
    chk(busy == 0, "R7 busy stays 0", busy, 0);
    chk(out_sel == 0, "R7 out_sel unchanged", out_sel, 0);
    chk(src_sel == 1, "R7 src_sel unchanged", src_sel, 1);
    repeat (N + 2) @(negedge clk);
    chk(out_sel == 0, "R7 no late restore", out_sel, 0);
    err_clr = 1; @(negedge clk); err_clr = 0;
    chk(err == 0, "R8 err cleared again", err, 0);

    // R8 set wins over clear
    e.due = cyc + 1 + N; e.exp_out = 1; e.exp_src = 1; q.push_back(e);
    restore_req = 1; @(negedge clk); restore_req = 0;
    park_req = 1; err_clr = 1; @(negedge clk); park_req = 0; err_clr = 0;
    chk(err == 1, "R8 set wins", err, 1);
    while (cyc < e.due) @(negedge clk);
    @(negedge clk);
    chk(out_sel == 1, "R6 ignored park", out_sel, 1);

    chk(q.size() == 0, "R5 all phases completed", q.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule